// File: doc/BRIEF.md
# Superpage Promotion Decision Unit

This unit watches TLB miss events. Each event carries a virtual page number for 8 KB base pages, so the page offset is address bits 12:0 and the VPN is the part above them. The unit decides when an aligned group of contiguous virtual pages should become one superpage. A group of `SP_PAGES` base pages forms a region. A miss costs one unit. Promoting a region costs `THRESH` units, because the pages must be copied into contiguous physical memory. The unit waits until a region has spent as much on misses as the copy would cost, and then asks for promotion. This break-even rule keeps the total spend within twice what a choice made with full hindsight would cost.

A small fully associative table holds one counter per tracked region. Replacement is least recently missed. When a counter reaches the threshold, the unit presents one promotion request carrying the base VPN of the region. It holds the request until an acknowledgement pulse arrives. After that the region is marked as promoted and is not requested again until a demote pulse for that region releases its slot. The copy itself, the page table update and the TLB shootdown belong to other logic.

Top module: `superpage_promoter`

## Requirements
- R1: A miss maps to region `vpn >> log2(SP_PAGES)`. All VPNs of one region share one counter. `req_vpn` is the region number shifted back left, so its low `log2(SP_PAGES)` bits are zero.
- R2: A region that is not tracked starts with a count of 1 on its first miss. `req_valid` rises right after the clock edge that samples the `THRESH`-th miss of that region, and not earlier.
- R3: Once raised, `req_valid` and `req_vpn` hold steady until a cycle with `done_valid` high. After that cycle the request for that region is gone.
- R4: While a region is requested or promoted, its misses have no effect. After `done_valid`, misses to the promoted region never raise a request again.
- R5: A demote pulse whose VPN lies in a promoted region frees that slot. The region then needs a fresh `THRESH` misses before it is requested again.
- R6: At most one request is outstanding. A region that reaches the threshold while another request is outstanding keeps its count saturated at `THRESH`. Its request appears right after the edge that samples the `done_valid` of the earlier one.
- R7: When no slot is free, a new region takes the slot of the tracking region whose last miss is oldest. The evicted region loses its count and restarts at 1.
- R8: Requested and promoted slots are never evicted. If every slot is in one of those states, misses to untracked regions are dropped.
- R9: `done_valid` with no request outstanding is ignored. A demote whose region is tracked but not promoted is ignored, and the count is kept.
- R10: After reset no region is tracked and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | One TLB miss this cycle |
| miss_vpn | input | VPN_W | VPN of the miss |
| done_valid | input | 1 | Promotion of the requested region finished |
| demote_valid | input | 1 | Release a promoted region |
| demote_vpn | input | VPN_W | Any VPN inside the region to release |
| req_valid | output | 1 | Promotion request outstanding |
| req_vpn | output | VPN_W | Base VPN of the region to promote |

## Verification
The bench sweeps every region of a small configuration through the full sequence: count, request, acknowledge, ignored misses, demote and re-request. A design with an off-by-one threshold, or one that keys counters on the whole VPN, would raise the request a miss early or late, or would carry unaligned base bits. Separate scenes fill the table. In them an eviction that picks the wrong slot leaves a stale count that fires early, and evicting pinned slots would let a promoted region be requested twice. A second region saturating behind an outstanding request has to appear exactly one edge after the acknowledgement. Stray acknowledge and demote pulses must not disturb the counts.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_PEND  = 2'd2,
        ST_PROMO = 2'd3
    } slot_state_e;
endpackage

// File: rtl/sp_region_map.sv
module sp_region_map #(
    parameter int VPN_W = 35,
    parameter int SHIFT = 4,
    localparam int REG_W = VPN_W - SHIFT
) (
    input  logic [VPN_W-1:0] vpn_i,
    output logic [REG_W-1:0] rgn_o
);
    assign rgn_o = vpn_i[VPN_W-1:SHIFT];
endmodule

// File: rtl/sp_lru_ages.sv
module sp_lru_ages #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           touch_en,
    input  logic [IDX_W-1:0]               touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0]  age_o
);
    logic [ENTRIES-1:0][IDX_W-1:0] age_d, age_q;

    always_comb begin
        logic [IDX_W-1:0] cur;
        age_d = age_q;
        cur   = age_q[touch_idx];
        if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < cur)
                    age_d[i] = age_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    assign age_o = age_q;

    // ages must always stay a permutation of 0..ENTRIES-1
    logic [ENTRIES-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (int'(age_q[i]) < ENTRIES) seen[age_q[i]] = 1'b1;
    end

    p_age_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        &seen)
        else $error("age table lost its permutation");
endmodule

// File: rtl/sp_victim_pick.sv
module sp_victim_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             free_mask_i,
    input  logic [ENTRIES-1:0]             evict_mask_i,
    input  logic [ENTRIES-1:0][IDX_W-1:0]  age_i,
    output logic                           have_free_o,
    output logic [IDX_W-1:0]               free_idx_o,
    output logic                           have_victim_o,
    output logic [IDX_W-1:0]               victim_idx_o
);
    always_comb begin
        logic [IDX_W-1:0] best_age;
        have_free_o   = 1'b0;
        free_idx_o    = '0;
        have_victim_o = 1'b0;
        victim_idx_o  = '0;
        best_age      = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (free_mask_i[i] && !have_free_o) begin
                have_free_o = 1'b1;
                free_idx_o  = IDX_W'(i);
            end
            if (evict_mask_i[i] && (!have_victim_o || age_i[i] > best_age)) begin
                have_victim_o = 1'b1;
                victim_idx_o  = IDX_W'(i);
                best_age      = age_i[i];
            end
        end
    end
endmodule

// File: rtl/superpage_promoter.sv
module superpage_promoter
    import sp_pkg::*;
#(
    parameter int VPN_W    = 35,
    parameter int SP_PAGES = 16,
    parameter int THRESH   = 10,
    parameter int ENTRIES  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             done_valid,
    input  logic             demote_valid,
    input  logic [VPN_W-1:0] demote_vpn,
    output logic             req_valid,
    output logic [VPN_W-1:0] req_vpn
);
    localparam int SHIFT = $clog2(SP_PAGES);
    localparam int REG_W = VPN_W - SHIFT;
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    typedef struct packed {
        slot_state_e      st;
        logic [REG_W-1:0] rgn;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } tbl_t;

    tbl_t s_d, s_q;

    logic [REG_W-1:0] miss_rgn, dem_rgn;

    sp_region_map #(.VPN_W(VPN_W), .SHIFT(SHIFT)) i_map_miss (
        .vpn_i(miss_vpn), .rgn_o(miss_rgn)
    );
    sp_region_map #(.VPN_W(VPN_W), .SHIFT(SHIFT)) i_map_dem (
        .vpn_i(demote_vpn), .rgn_o(dem_rgn)
    );

    logic [ENTRIES-1:0]            free_mask, evict_mask, pend_mask;
    logic [ENTRIES-1:0][IDX_W-1:0] ages;
    logic                          have_free, have_victim;
    logic [IDX_W-1:0]              free_idx, victim_idx;
    logic                          touch_en;
    logic [IDX_W-1:0]              touch_idx;
    logic                          pend_any;
    logic [IDX_W-1:0]              pend_idx;

    // scan of the registered table
    always_comb begin
        free_mask  = '0;
        evict_mask = '0;
        pend_mask  = '0;
        pend_any   = 1'b0;
        pend_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            free_mask[i]  = (s_q.slot[i].st == ST_FREE);
            evict_mask[i] = (s_q.slot[i].st == ST_TRACK);
            pend_mask[i]  = (s_q.slot[i].st == ST_PEND);
            if (pend_mask[i] && !pend_any) begin
                pend_any = 1'b1;
                pend_idx = IDX_W'(i);
            end
        end
    end

    sp_victim_pick #(.ENTRIES(ENTRIES)) i_pick (
        .free_mask_i  (free_mask),
        .evict_mask_i (evict_mask),
        .age_i        (ages),
        .have_free_o  (have_free),
        .free_idx_o   (free_idx),
        .have_victim_o(have_victim),
        .victim_idx_o (victim_idx)
    );

    sp_lru_ages #(.ENTRIES(ENTRIES)) i_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_en (touch_en),
        .touch_idx(touch_idx),
        .age_o    (ages)
    );

    // next-state: acknowledge, demote, miss, then issue
    always_comb begin
        logic             hit;
        logic [IDX_W-1:0] hit_idx;
        logic             busy_n;
        logic             issued;
        s_d       = s_q;
        touch_en  = 1'b0;
        touch_idx = '0;
        hit       = 1'b0;
        hit_idx   = '0;

        if (done_valid && pend_any) begin
            s_d.slot[pend_idx].st  = ST_PROMO;
            s_d.slot[pend_idx].cnt = '0;
        end

        for (int i = 0; i < ENTRIES; i++) begin
            if (demote_valid && s_q.slot[i].st == ST_PROMO && s_q.slot[i].rgn == dem_rgn) begin
                s_d.slot[i].st  = ST_FREE;
                s_d.slot[i].cnt = '0;
            end
            if (s_q.slot[i].st != ST_FREE && s_q.slot[i].rgn == miss_rgn && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end

        if (miss_valid) begin
            if (hit) begin
                if (s_q.slot[hit_idx].st == ST_TRACK) begin
                    touch_en  = 1'b1;
                    touch_idx = hit_idx;
                    if (s_q.slot[hit_idx].cnt < LIMIT)
                        s_d.slot[hit_idx].cnt = s_q.slot[hit_idx].cnt + 1'b1;
                end
            end else if (have_free || have_victim) begin
                touch_en  = 1'b1;
                touch_idx = have_free ? free_idx : victim_idx;
                s_d.slot[touch_idx].st  = ST_TRACK;
                s_d.slot[touch_idx].rgn = miss_rgn;
                s_d.slot[touch_idx].cnt = CNT_W'(1);
            end
        end

        busy_n = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (s_d.slot[i].st == ST_PEND) busy_n = 1'b1;
        issued = busy_n;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!issued && s_d.slot[i].st == ST_TRACK && s_d.slot[i].cnt == LIMIT) begin
                s_d.slot[i].st = ST_PEND;
                issued = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                s_q.slot[i].st  <= ST_FREE;
                s_q.slot[i].rgn <= '0;
                s_q.slot[i].cnt <= '0;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid = pend_any;
    assign req_vpn   = {s_q.slot[pend_idx].rgn, {SHIFT{1'b0}}};

    // ---------------- assertions ----------------
    p_single_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_mask))
        else $error("more than one request outstanding");

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !done_valid |=> req_valid && $stable(req_vpn))
        else $error("request dropped or changed before acknowledge");

    p_req_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && done_valid |=> !(req_valid && req_vpn == $past(req_vpn)))
        else $error("request survived its acknowledge");

    p_idle_after_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> !req_valid)
        else $error("request present out of reset");

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot_chk
        p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.slot[g].cnt <= LIMIT)
            else $error("counter passed threshold");
        p_promo_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.slot[g].st == ST_PROMO && !demote_valid |=> s_q.slot[g].st == ST_PROMO)
            else $error("promoted slot left without demote");
    end
endmodule

// File: tb/test_superpage_promoter.sv
module test_superpage_promoter;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W = 8;
    localparam int SP_PAGES = 4;
    localparam int THRESH = 3;
    localparam int ENTRIES = 4;
    localparam int NREG = 1 << (VPN_W - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0, done_valid = 1'b0, demote_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0, demote_vpn = '0;
    logic req_valid;
    logic [VPN_W-1:0] req_vpn;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    superpage_promoter #(.VPN_W(VPN_W), .SP_PAGES(SP_PAGES), .THRESH(THRESH), .ENTRIES(ENTRIES))
    i_superpage_promoter (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .done_valid(done_valid), .demote_valid(demote_valid), .demote_vpn(demote_vpn),
        .req_valid(req_valid), .req_vpn(req_vpn)
    );

    task automatic chk(string tag, bit ev, logic [VPN_W-1:0] evpn);
        total++;
        if (req_valid !== ev || (ev && req_vpn !== evpn)) begin
            bad++;
            $display("FAIL %s: req_valid=%0b req_vpn=%0h expected valid=%0b vpn=%0h",
                     tag, req_valid, req_vpn, ev, evpn);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic miss(input logic [VPN_W-1:0] v);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_vpn = v;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic done();
        @(negedge clk);
        done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic demote(input logic [VPN_W-1:0] v);
        @(negedge clk);
        demote_valid = 1'b1;
        demote_vpn = v;
        @(negedge clk);
        demote_valid = 1'b0;
    endtask

    function automatic logic [VPN_W-1:0] vp(int r, int off);
        return VPN_W'(r * SP_PAGES + off);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R10 reset idle", 1'b0, '0);

        // R9: stray acknowledge, then demote of a tracking region
        done();
        chk("R9 stray done", 1'b0, '0);
        miss(vp(5, 0));
        miss(vp(5, 1));
        demote(vp(5, 2));
        chk("R9 demote tracking", 1'b0, '0);
        miss(vp(5, 3));
        chk("R9 count kept after demote", 1'b1, vp(5, 0));
        done();
        demote(vp(5, 0));

        // R1 R2 R3 R4 R5 sweep over every region
        for (int r = 0; r < NREG; r++) begin
            miss(vp(r, 0));
            chk("R2 first miss", 1'b0, '0);
            miss(vp(r, 3));
            chk("R2 second miss", 1'b0, '0);
            miss(vp(r, 1));
            chk("R1 R2 threshold request", 1'b1, vp(r, 0));
            miss(vp(r, 2));
            chk("R4 miss while pending", 1'b1, vp(r, 0));
            @(negedge clk);
            chk("R3 hold", 1'b1, vp(r, 0));
            done();
            chk("R3 released", 1'b0, '0);
            for (int k = 0; k < THRESH + 1; k++) miss(vp(r, k % SP_PAGES));
            chk("R4 promoted ignored", 1'b0, '0);
            demote(vp(r, 2));
            miss(vp(r, 1));
            miss(vp(r, 1));
            chk("R5 not yet after demote", 1'b0, '0);
            miss(vp(r, 0));
            chk("R5 re-request", 1'b1, vp(r, 0));
            done();
            demote(vp(r, 3));
        end

        // R6: second region waits behind an outstanding request
        do_reset();
        for (int k = 0; k < THRESH; k++) miss(vp(7, k));
        chk("R6 first request", 1'b1, vp(7, 0));
        for (int k = 0; k < THRESH + 2; k++) miss(vp(9, k % SP_PAGES));
        chk("R6 second waits", 1'b1, vp(7, 0));
        done();
        chk("R6 second issued after done", 1'b1, vp(9, 0));
        done();
        chk("R6 both served", 1'b0, '0);

        // R7: eviction of the least recently missed tracking slot
        do_reset();
        miss(vp(1, 0));
        miss(vp(2, 0));
        miss(vp(3, 0));
        miss(vp(4, 0));
        miss(vp(1, 1));
        miss(vp(6, 0));
        miss(vp(2, 1));
        miss(vp(2, 2));
        chk("R7 evicted count restarted", 1'b0, '0);
        miss(vp(2, 3));
        chk("R7 request after restart", 1'b1, vp(2, 0));
        done();
        miss(vp(1, 2));
        chk("R7 survivor kept count", 1'b1, vp(1, 0));
        done();

        // R8: all slots pinned, untracked misses dropped
        do_reset();
        for (int r = 10; r < 10 + ENTRIES; r++) begin
            for (int k = 0; k < THRESH; k++) miss(vp(r, k));
            chk("R8 fill promote", 1'b1, vp(r, 0));
            done();
        end
        for (int k = 0; k < THRESH; k++) miss(vp(20, k));
        chk("R8 dropped when pinned", 1'b0, '0);
        demote(vp(12, 0));
        for (int k = 0; k < THRESH; k++) miss(vp(20, k));
        chk("R8 tracked after slot freed", 1'b1, vp(20, 0));
        done();
        for (int k = 0; k < THRESH; k++) miss(vp(11, k));
        chk("R8 promoted not evicted", 1'b0, '0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule